// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is the target end of a byte-wide memory reached over a two-wire serial bus (I2C). The bus clock and data lines are sampled by a much faster system clock. The block recognises Start, repeated Start and Stop conditions on the sampled lines and takes part in a transfer only when the control byte carries the fixed device tag and a chip-select field that matches its three strap pins. It drives the data line only through an active-high pull-low enable, so the pad behaves as open drain.

A write transfer sends a two-byte word address, high part first, and then optional data bytes. A data byte is stored only while the write-protect pin is low. The block keeps a 12-bit address pointer that persists from one transfer to the next. Any of three read forms is served from this pointer. A random read is a write that stops after the address bytes and is followed by a repeated Start. A current-address read starts directly with a read control byte. A sequential read continues for as long as the controller acknowledges each byte.

Top module: `i2cmem_target`

## Requirements
- R1: After reset, and at any time the block is not engaged in a transfer, `sda_oe` is low.
- R2: A control byte is accepted only when bits 7..4 equal 1010 and bits 3..1 equal `strap_sel[2:1:0]`. Bit 0 selects read (1) or write (0). An accepted control byte is acknowledged. On a mismatch the block leaves SDA released until the next Start, and the pointer is unchanged.
- R3: In a write transfer the next two bytes form the word address. The high byte comes first and only its low 4 bits are used, so its upper nibble has no effect. Both address bytes are acknowledged.
- R4: While `wr_protect` is low, each data byte that follows the address is acknowledged and stored at the pointer, and the pointer then advances by one. Further bytes go to consecutive locations.
- R5: While `wr_protect` is high, data bytes are still acknowledged and still advance the pointer, but the array is left unchanged.
- R6: A write carrying only the two address bytes, followed by a repeated Start and a read control byte, returns the byte at that address. No array write takes place.
- R7: Read data is sent most significant bit first. Each bit is set up after an SCL falling edge and is stable while SCL is high. SDA is released during the controller's acknowledge slot.
- R8: An acknowledge from the controller after a read byte causes the next location to be sent. A not-acknowledge ends the transmission and SDA stays released.
- R9: The pointer wraps from 0xFFF to 0x000, for reads and for writes.
- R10: A read control byte that follows no address returns the byte at the pointer, which is the location after the last one accessed.
- R11: A Start or Stop seen in the middle of a byte abandons that byte. After a Start, a new control byte is expected from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_sel | input | 3 | Chip-select straps compared with control byte bits 3..1 |
| wr_protect | input | 1 | High blocks array writes |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The bench sends the high address byte with a non-zero upper nibble. A design that decoded those bits would read back the wrong location. Sequential reads and multi-byte writes cross 0xFFF, so a pointer that saturated or carried into unused bits would return wrong data. The bench checks, on every clock, that the data line is released whenever the controller owns it: during its data bits, during its acknowledge slot, and throughout a transfer with a mismatched chip select. An acknowledge driven late, or a target that answered the wrong straps, would pull the line low there. A write-protected write is followed by a current-address read and a random read. A design that stored the byte anyway would fail the random read, and one that froze the pointer would fail the current-address read. A Start that interrupts a half-sent byte must not leave stale bits in the next control byte.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_READ
  } phase_t;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/i2cmem_linesync.sv
module i2cmem_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_lvl;
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2cmem_storage.sv
module i2cmem_storage #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_sel,
  input  logic       wr_protect,
  output logic       sda_oe
);
  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam logic [3:0] CNT_ACK = 4'd8;
  localparam logic [3:0] CNT_END = 4'd9;

  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  phase_t phase, phase_nx;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr;
  logic              oe_q, mst_ack, ctrl_hit, mem_we;
  logic [BYTE_W-1:0] rdata;

  i2cmem_linesync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cmem_storage #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(shreg), .rdata(rdata)
  );

  assign ctrl_hit = (shreg[7:4] == DEV_TAG) && (shreg[3:1] == strap_sel);
  assign mem_we   = (phase == PH_WDAT) && scl_fall && (bitcnt == CNT_ACK)
                    && !wr_protect && !start_ev && !stop_ev;
  assign sda_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      phase_nx <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      hi_q     <= '0;
      ptr      <= '0;
      oe_q     <= 1'b0;
      mst_ack  <= 1'b0;
    end else if (start_ev) begin
      phase  <= PH_CTRL;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (stop_ev) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < CNT_ACK) begin
          if (phase != PH_READ) shreg <= {shreg[BYTE_W-2:0], sda_lvl};
        end else if (bitcnt == CNT_ACK) begin
          mst_ack <= !sda_lvl;
        end
        if (bitcnt != CNT_END) bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (phase == PH_READ) begin
          if (bitcnt == CNT_ACK) begin
            oe_q <= 1'b0;
          end else if (bitcnt == CNT_END) begin
            bitcnt <= '0;
            if (mst_ack) begin
              shreg <= rdata;
              oe_q  <= !rdata[BYTE_W-1];
              ptr   <= ptr + 1'b1;
            end else begin
              phase <= PH_IDLE;
              oe_q  <= 1'b0;
            end
          end else if (bitcnt != 4'd0) begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            oe_q  <= !shreg[BYTE_W-2];
          end
        end else if (bitcnt == CNT_ACK) begin
          unique case (phase)
            PH_CTRL: begin
              if (ctrl_hit) begin
                oe_q     <= 1'b1;
                phase_nx <= shreg[0] ? PH_READ : PH_AHI;
              end else begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
              end
            end
            PH_AHI: begin
              hi_q     <= shreg[HI_W-1:0];
              oe_q     <= 1'b1;
              phase_nx <= PH_ALO;
            end
            PH_ALO: begin
              ptr      <= {hi_q, shreg};
              oe_q     <= 1'b1;
              phase_nx <= PH_WDAT;
            end
            PH_WDAT: begin
              ptr      <= ptr + 1'b1;
              oe_q     <= 1'b1;
              phase_nx <= PH_WDAT;
            end
            default: ;
          endcase
        end else if (bitcnt == CNT_END) begin
          bitcnt <= '0;
          phase  <= phase_nx;
          if (phase_nx == PH_READ) begin
            shreg <= rdata;
            oe_q  <= !rdata[BYTE_W-1];
            ptr   <= ptr + 1'b1;
          end else begin
            oe_q <= 1'b0;
          end
        end
      end
    end
  end

  // R1: never driving while disengaged
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);

  // R2: in receive phases the line is only pulled in the acknowledge slot
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_READ && sda_oe) |-> (bitcnt >= CNT_ACK));

  // R7: transmitted bits only change on a falling SCL or a bus condition
  p_bit_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && !scl_fall && !start_ev && !stop_ev) |=> $stable(sda_oe));

  // R9: pointer wraps to zero on an acknowledged read at the top address
  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && scl_fall && bitcnt == CNT_END && mst_ack && (&ptr)
     && !start_ev && !stop_ev) |=> (ptr == '0));

  // R11: a Start always restarts the byte at the control phase
  p_start_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (phase == PH_CTRL && bitcnt == 4'd0 && !sda_oe));
endmodule

// File: tb/i2cmem_target_bench.sv
module i2cmem_target_bench;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda;
  assign sda = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic exp_release = 1'b0;
  logic quiet = 1'b0;
  string rel_req = "R7";

  logic [7:0] ref_mem [0:4095];
  int ref_ptr = 0;

  always #10 clk = ~clk;

  i2cmem_target u_i2cmem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .strap_sel(STRAP), .wr_protect(wp), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference: the target must not pull while the controller owns SDA
  always @(negedge clk) begin
    if (rst_n && (exp_release || quiet)) begin
      checks++;
      if (sda_oe) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", quiet ? "R2" : rel_req, 1, 0);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b0; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; wq(1); scl = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(1); scl = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(1); exp_release = 1'b1;
      scl = 1'b1; wq(2); scl = 1'b0;
      if (i == 0) exp_release = 1'b0;
      wq(1);
    end
    exp_release = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(1); scl = 1'b1; wq(1);
    ack = ~sda; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; wq(1); b[i] = sda; wq(1); scl = 1'b0; wq(2);
    end
    rel_req = give_ack ? "R8" : "R7";
    sda_m = ~give_ack; exp_release = 1'b1;
    scl = 1'b1; wq(2); scl = 1'b0; exp_release = 1'b0; wq(1); sda_m = 1'b1;
  endtask

  task automatic send_addr(input int addr, input logic [3:0] junk);
    logic a;
    send_byte({junk, 4'(addr >> 8)}, a); check(a, "R3", a, 1);
    send_byte(8'(addr), a);             check(a, "R3", a, 1);
  endtask

  task automatic write_seq(input int addr, input logic [7:0] dq[$]);
    logic a;
    do_start();
    send_byte(CW, a); check(a, "R2", a, 1);
    send_addr(addr, 4'hC);
    ref_ptr = addr;
    foreach (dq[k]) begin
      send_byte(dq[k], a); check(a, wp ? "R5" : "R4", a, 1);
      if (!wp) ref_mem[ref_ptr] = dq[k];
      ref_ptr = (ref_ptr + 1) % 4096;
    end
    do_stop();
  endtask

  task automatic read_tail(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      check(b === ref_mem[ref_ptr], req, b, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 4096;
    end
    do_stop();
  endtask

  task automatic read_rand(input int addr, input int n, input string req);
    logic a;
    do_start();
    send_byte(CW, a); check(a, "R6", a, 1);
    send_addr(addr, 4'h7);
    do_rstart();
    send_byte(CR, a); check(a, "R6", a, 1);
    ref_ptr = addr;
    read_tail(n, req);
  endtask

  task automatic read_cur(input int n, input string req);
    logic a;
    do_start();
    send_byte(CR, a); check(a, "R10", a, 1);
    read_tail(n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    repeat (10) @(negedge clk);
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R1", sda_oe, 0);

    // R4 multi-byte write, R3 upper nibble ignored
    write_seq(12'h123, '{8'h5C, 8'h42});
    // R6 random read; R7 bit order
    read_rand(12'h123, 1, "R6");
    // R9 write across the top address
    write_seq(12'hFFE, '{8'hA1, 8'hB2, 8'hC3});
    write_seq(12'h001, '{8'h77});
    // R8/R9 sequential read wrapping
    read_rand(12'hFFE, 4, "R9");
    write_seq(12'h002, '{8'h3E});
    write_seq(12'h003, '{8'h99});
    read_rand(12'h002, 1, "R6");
    // R10 current-address read
    read_cur(1, "R10");

    // R5 protected write leaves array, advances pointer
    wp = 1'b1;
    write_seq(12'h123, '{8'hEE});
    wp = 1'b0;
    read_cur(1, "R5");
    read_rand(12'h123, 1, "R5");

    // R2 mismatched write and read: no acknowledge, line stays released
    quiet = 1'b1;
    do_start();
    send_byte({4'b1010, 3'b000, 1'b0}, a); check(!a, "R2", a, 0);
    send_byte(8'h01, a);                   check(!a, "R2", a, 0);
    do_rstart();
    send_byte({4'b1010, 3'b100, 1'b1}, a); check(!a, "R2", a, 0);
    recv_byte(1'b0, b);                    check(b == 8'hFF, "R2", b, 8'hFF);
    do_stop();
    send_byte(8'h00, a);
    quiet = 1'b0;
    do_start();
    send_byte({4'b0110, STRAP, 1'b0}, a); check(!a, "R2", a, 0);
    do_stop();
    // pointer untouched by the rejected transfers
    read_cur(1, "R2");

    // R11 Start in the middle of a byte
    do_start();
    send_bits(8'h0F, 4);
    do_rstart();
    send_byte(CW, a); check(a, "R11", a, 1);
    send_addr(12'h010, 4'h3);
    send_byte(8'h6D, a); check(a, "R11", a, 1);
    ref_mem[12'h010] = 8'h6D;
    do_stop();
    read_rand(12'h010, 1, "R11");
    // R11 Stop in the middle of a byte
    do_start();
    send_byte(CW, a); check(a, "R11", a, 1);
    send_bits(8'hFF, 3);
    do_stop();
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    read_rand(12'h001, 1, "R11");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule